// File: doc/BRIEF.md
# Backplane SPI Host with Serial Device-Select Loader

This controller sits on the host card of a backplane and serves peripheral cards in slots 1 to 7. Each slot has its own serial clock, MOSI, MISO, one card-select line and one latch-strobe line. Each card holds an external shift register with parallel outputs. Those outputs pick which device on the card answers. The controller first loads that register and latches it, and only then runs the data transfer on the card.

A request gives the slot, the device index, the byte count and, one byte at a time, the transmit data. The controller answers in two phases. In the first phase, with card select high, it shifts a select pattern of `8*CHAIN_LEN` bits at the fastest serial rate, with one system cycle per clock half. It then pulses the latch strobe. In the second phase it drives card select low and moves the bytes in SPI mode 0, at a half-period set per slot. After the last byte it raises card select and loads and latches an all-ones pattern, so that no device on the card stays selected. Received bytes come out one by one with a valid strobe. A `done` pulse marks the end of each request.

Top module: `bpSpiHost`

## Requirements
- R1: A request is rejected if the slot is 0 or above `NUM_SLOTS`, if the device index is `8*CHAIN_LEN` or more, or if the byte count is 0. A rejection raises `done` and `err` together for one cycle in the cycle after the request. `busy` stays low, and no pin of any slot moves.
- R2: Before card select falls, the addressed slot's register receives a pattern of `8*CHAIN_LEN` bits, MSB first. The bits are clocked on rising SCLK edges while card select is high. The pattern has a single 0 at bit `8*CHAIN_LEN-1-dev`, and every other bit is 1. For one register, device 0 is 0111_1111 and device 1 is 1011_1111.
- R3: During the select shifts, SCLK stays high for exactly one system cycle per pulse.
- R4: After the select pattern, the slot's latch strobe is high for two system cycles while card select is high. Card select goes low only after the strobe ends.
- R5: The data phase uses SPI mode 0. MOSI is sent MSB first and changes only while SCLK is low. MISO is sampled on the rising edge. Exactly `len` bytes are sent, and `txTake` pulses once for each byte, in the cycle in which `txByte` is consumed.
- R6: In the data phase, SCLK is high and low for `div+1` system cycles each. `div` is the slot's divider register. After reset this register is `FAST_DIV` (1) for slots 1 to `FAST_SLOTS` (2) and `SLOW_DIV` (5) for the other slots. A `cfgWe` write replaces it for later requests.
- R7: Each received byte appears on `rxData` with a one-cycle `rxValid`, in order, `len` times in total.
- R8: After the last byte, card select goes high and an all-ones pattern is shifted and latched. Then `done` pulses for one cycle with `err` low, and `busy` returns low. Card select changes only while SCLK is low.
- R9: Only the addressed slot's pins move. On every other slot, SCLK, MOSI and the strobe stay low and card select stays high. MISO from the other slots has no effect on the received data.
- R10: During reset and after it, every card select is high, and SCLK, MOSI, the strobes, `busy`, `done`, `err` and `rxValid` are all low.
- R11: With `CHAIN_LEN` above 1, the pattern is `8*CHAIN_LEN` bits long, and device indices 8 to `8*CHAIN_LEN-1` are served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, taken while idle |
| reqSlot | input | SLOT_W | Target slot, 1 to NUM_SLOTS |
| reqDev | input | DEV_W | Device index on the card |
| reqLen | input | LEN_W | Byte count |
| txByte | input | 8 | Next byte to send |
| txTake | output | 1 | `txByte` consumed this cycle |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Rejection flag, pulsed with `done` |
| rxData | output | 8 | Received byte |
| rxValid | output | 1 | `rxData` valid this cycle |
| cfgWe | input | 1 | Divider write enable |
| cfgSlot | input | SLOT_W | Slot whose divider is written |
| cfgDiv | input | DIV_W | New divider value |
| sclkO | output | NUM_SLOTS | Serial clock per slot |
| mosiO | output | NUM_SLOTS | Serial data out per slot |
| misoI | input | NUM_SLOTS | Serial data in per slot |
| csN | output | NUM_SLOTS | Active-low card select per slot |
| selStrobeO | output | NUM_SLOTS | Select-register latch strobe per slot |

## Verification
The bench builds the block with `CHAIN_LEN=2`. This gives 16-bit patterns, so device indices 8 to 15 can be reached, and index 16 becomes the first out-of-range value. The other parameters keep their defaults. That keeps the mix of two fast and five slow reset dividers, so both reset rates are measured. Divider writes of 0 and 2 add the shortest data half-period and one in between. A model card on the bench's side rebuilds the latched pattern from the pins. While that card answers on MISO, every other slot toggles its MISO line as noise.

// File: rtl/bpHostPkg.sv
package bpHostPkg;

  // What the datapath loads into its shifter when control starts it.
  typedef enum logic [1:0] {
    LD_NONE,
    LD_SEL,
    LD_ONES,
    LD_BYTE
  } loadKindT;

  // Strobes and levels from control to the datapath.
  typedef struct packed {
    loadKindT ld;
    logic     csOn;
    logic     strobeOn;
    logic     active;
  } ctlStrobeT;

endpackage

// File: rtl/bpSpiCtrl.sv
module bpSpiCtrl
  import bpHostPkg::*;
#(
  parameter int NUM_SLOTS = 7,
  parameter int SEL_W     = 8,
  parameter int LEN_W     = 4,
  parameter int SLOT_W    = 3,
  parameter int DEV_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [SLOT_W-1:0] reqSlot,
  input  logic [DEV_W-1:0]  reqDev,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic              engDone,
  output ctlStrobeT         ctl,
  output logic [SLOT_W-1:0] slotCur,
  output logic [DEV_W-1:0]  devCur,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              txTake,
  output logic              rxValid
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_LATCH,
    ST_DATA,
    ST_CLR,
    ST_CLATCH
  } stateT;

  stateT             state;
  logic [SLOT_W-1:0] slotQ;
  logic [DEV_W-1:0]  devQ;
  logic [LEN_W-1:0]  bytesLeft;
  logic              latchCnt;
  logic              csActive;
  logic              doneQ;
  logic              errQ;
  logic              reqOk;
  loadKindT          ldKind;

  assign reqOk = (reqSlot != '0) && (int'(reqSlot) <= NUM_SLOTS) &&
                 (int'(reqDev) < SEL_W) && (reqLen != '0);

  always_comb begin
    ldKind = LD_NONE;
    case (state)
      ST_IDLE:  if (reqValid && reqOk) ldKind = LD_SEL;
      ST_LATCH: if (latchCnt) ldKind = LD_BYTE;
      ST_DATA:  if (engDone) ldKind = (bytesLeft == LEN_W'(1)) ? LD_ONES : LD_BYTE;
      default:  ldKind = LD_NONE;
    endcase
  end

  always_comb begin
    ctl.ld       = ldKind;
    ctl.csOn     = csActive;
    ctl.strobeOn = (state == ST_LATCH) || (state == ST_CLATCH);
    ctl.active   = (state != ST_IDLE);
  end

  assign slotCur = (state == ST_IDLE) ? reqSlot : slotQ;
  assign devCur  = (state == ST_IDLE) ? reqDev  : devQ;
  assign busy    = (state != ST_IDLE);
  assign done    = doneQ;
  assign err     = errQ;
  assign txTake  = (ldKind == LD_BYTE);
  assign rxValid = (state == ST_DATA) && engDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      slotQ     <= '0;
      devQ      <= '0;
      bytesLeft <= '0;
      latchCnt  <= 1'b0;
      csActive  <= 1'b0;
      doneQ     <= 1'b0;
      errQ      <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      errQ  <= 1'b0;
      case (state)
        ST_IDLE: begin
          latchCnt <= 1'b0;
          if (reqValid) begin
            if (reqOk) begin
              slotQ     <= reqSlot;
              devQ      <= reqDev;
              bytesLeft <= reqLen;
              state     <= ST_SEL;
            end else begin
              doneQ <= 1'b1;
              errQ  <= 1'b1;
            end
          end
        end
        ST_SEL: begin
          if (engDone) begin
            latchCnt <= 1'b0;
            state    <= ST_LATCH;
          end
        end
        ST_LATCH: begin
          if (latchCnt) begin
            csActive <= 1'b1;
            state    <= ST_DATA;
          end else begin
            latchCnt <= 1'b1;
          end
        end
        ST_DATA: begin
          if (engDone) begin
            if (bytesLeft == LEN_W'(1)) begin
              csActive <= 1'b0;
              state    <= ST_CLR;
            end else begin
              bytesLeft <= bytesLeft - LEN_W'(1);
            end
          end
        end
        ST_CLR: begin
          if (engDone) begin
            latchCnt <= 1'b0;
            state    <= ST_CLATCH;
          end
        end
        ST_CLATCH: begin
          if (latchCnt) begin
            doneQ <= 1'b1;
            state <= ST_IDLE;
          end else begin
            latchCnt <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ERR_HAS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    errQ |-> doneQ); // R1
  AST_CS_AFTER_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csActive) |-> ($past(state) == ST_LATCH)); // R4
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> (state == ST_IDLE)); // R8
  AST_BYTE_UNDER_CS: assert property (@(posedge clk) disable iff (!rstN)
    (ldKind == LD_BYTE) |=> csActive); // R5

endmodule

// File: rtl/bpSpiPath.sv
module bpSpiPath
  import bpHostPkg::*;
#(
  parameter int NUM_SLOTS  = 7,
  parameter int SEL_W      = 8,
  parameter int DIV_W      = 8,
  parameter int SLOT_W     = 3,
  parameter int DEV_W      = 4,
  parameter int FAST_SLOTS = 2,
  parameter int FAST_DIV   = 1,
  parameter int SLOW_DIV   = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctlStrobeT            ctl,
  input  logic [SLOT_W-1:0]    slotIdx,
  input  logic [DEV_W-1:0]     devIdx,
  input  logic [7:0]           txByte,
  input  logic                 cfgWe,
  input  logic [SLOT_W-1:0]    cfgSlot,
  input  logic [DIV_W-1:0]     cfgDiv,
  input  logic [NUM_SLOTS-1:0] misoI,
  output logic [NUM_SLOTS-1:0] sclkO,
  output logic [NUM_SLOTS-1:0] mosiO,
  output logic [NUM_SLOTS-1:0] csN,
  output logic [NUM_SLOTS-1:0] selStrobeO,
  output logic                 engDone,
  output logic [7:0]           rxByte
);

  localparam int CNT_W  = $clog2(SEL_W + 1);
  localparam int HALF_W = DIV_W + 1;

  logic [SEL_W-1:0]              shReg;
  logic [SEL_W-1:0]              selPat;
  logic [CNT_W-1:0]              bitsLeft;
  logic [HALF_W-1:0]             halfCnt;
  logic [HALF_W-1:0]             halfLen;
  logic [HALF_W-1:0]             byteHalf;
  logic                          sclkR;
  logic                          running;
  logic [7:0]                    rxReg;
  logic                          misoSel;
  logic [DIV_W-1:0]              divSel;
  logic [NUM_SLOTS-1:0][DIV_W-1:0] divVec;
  logic [NUM_SLOTS-1:0]          hit;

  // One zero at the addressed device's position, ones elsewhere.
  always_comb begin
    selPat = ~({{(SEL_W-1){1'b0}}, 1'b1} << (SEL_W - 1 - int'(devIdx)));
  end

  always_comb begin
    misoSel = 1'b0;
    divSel  = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (int'(slotIdx) == i + 1) begin
        misoSel = misoI[i];
        divSel  = divVec[i];
      end
    end
  end

  assign byteHalf = HALF_W'(divSel) + HALF_W'(1);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    localparam logic [DIV_W-1:0] RST_DIV =
      (i < FAST_SLOTS) ? DIV_W'(FAST_DIV) : DIV_W'(SLOW_DIV);
    logic [DIV_W-1:0] divQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                 divQ <= RST_DIV;
      else if (cfgWe && int'(cfgSlot) == i + 1)  divQ <= cfgDiv;
    end

    assign divVec[i]     = divQ;
    assign hit[i]        = ctl.active && (int'(slotIdx) == i + 1);
    assign sclkO[i]      = hit[i] & sclkR;
    assign mosiO[i]      = hit[i] & running & shReg[SEL_W-1];
    assign csN[i]        = ~(hit[i] & ctl.csOn);
    assign selStrobeO[i] = hit[i] & ctl.strobeOn;
  end

  // Bit engine: low half then high half per bit, shift on the falling edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg    <= '0;
      bitsLeft <= '0;
      halfCnt  <= '0;
      halfLen  <= '0;
      sclkR    <= 1'b0;
      running  <= 1'b0;
      rxReg    <= '0;
      rxByte   <= '0;
      engDone  <= 1'b0;
    end else begin
      engDone <= 1'b0;
      if (ctl.ld != LD_NONE) begin
        running <= 1'b1;
        sclkR   <= 1'b0;
        case (ctl.ld)
          LD_SEL: begin
            shReg    <= selPat;
            bitsLeft <= CNT_W'(SEL_W);
            halfLen  <= HALF_W'(1);
            halfCnt  <= HALF_W'(1);
          end
          LD_ONES: begin
            shReg    <= '1;
            bitsLeft <= CNT_W'(SEL_W);
            halfLen  <= HALF_W'(1);
            halfCnt  <= HALF_W'(1);
          end
          default: begin
            shReg    <= SEL_W'(txByte) << (SEL_W - 8);
            bitsLeft <= CNT_W'(8);
            halfLen  <= byteHalf;
            halfCnt  <= byteHalf;
          end
        endcase
      end else if (running) begin
        if (halfCnt > HALF_W'(1)) begin
          halfCnt <= halfCnt - HALF_W'(1);
        end else begin
          halfCnt <= halfLen;
          if (!sclkR) begin
            sclkR <= 1'b1;
            rxReg <= {rxReg[6:0], misoSel};
          end else begin
            sclkR <= 1'b0;
            shReg <= shReg << 1;
            if (bitsLeft == CNT_W'(1)) begin
              running <= 1'b0;
              engDone <= 1'b1;
              rxByte  <= rxReg;
            end else begin
              bitsLeft <= bitsLeft - CNT_W'(1);
            end
          end
        end
      end
    end
  end

  AST_ONE_CARD: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN)); // R9
  AST_STROBE_CS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (|selStrobeO) |-> (&csN)); // R4
  AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|sclkO) |-> $stable(mosiO)); // R5
  AST_CS_SCLK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(csN) |-> (sclkO == '0)); // R8

endmodule

// File: rtl/bpSpiHost.sv
module bpSpiHost
  import bpHostPkg::*;
#(
  parameter int NUM_SLOTS  = 7,
  parameter int CHAIN_LEN  = 1,
  parameter int LEN_W      = 4,
  parameter int DIV_W      = 8,
  parameter int FAST_SLOTS = 2,
  parameter int FAST_DIV   = 1,
  parameter int SLOW_DIV   = 5,
  localparam int SEL_W     = 8 * CHAIN_LEN,
  localparam int SLOT_W    = $clog2(NUM_SLOTS + 1),
  localparam int DEV_W     = $clog2(SEL_W) + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [SLOT_W-1:0]    reqSlot,
  input  logic [DEV_W-1:0]     reqDev,
  input  logic [LEN_W-1:0]     reqLen,
  input  logic [7:0]           txByte,
  output logic                 txTake,
  output logic                 busy,
  output logic                 done,
  output logic                 err,
  output logic [7:0]           rxData,
  output logic                 rxValid,
  input  logic                 cfgWe,
  input  logic [SLOT_W-1:0]    cfgSlot,
  input  logic [DIV_W-1:0]     cfgDiv,
  output logic [NUM_SLOTS-1:0] sclkO,
  output logic [NUM_SLOTS-1:0] mosiO,
  input  logic [NUM_SLOTS-1:0] misoI,
  output logic [NUM_SLOTS-1:0] csN,
  output logic [NUM_SLOTS-1:0] selStrobeO
);

  ctlStrobeT         ctl;
  logic [SLOT_W-1:0] slotCur;
  logic [DEV_W-1:0]  devCur;
  logic              engDone;

  bpSpiCtrl #(
    .NUM_SLOTS(NUM_SLOTS), .SEL_W(SEL_W), .LEN_W(LEN_W),
    .SLOT_W(SLOT_W), .DEV_W(DEV_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSlot(reqSlot),
    .reqDev(reqDev), .reqLen(reqLen), .engDone(engDone), .ctl(ctl),
    .slotCur(slotCur), .devCur(devCur), .busy(busy), .done(done),
    .err(err), .txTake(txTake), .rxValid(rxValid)
  );

  bpSpiPath #(
    .NUM_SLOTS(NUM_SLOTS), .SEL_W(SEL_W), .DIV_W(DIV_W), .SLOT_W(SLOT_W),
    .DEV_W(DEV_W), .FAST_SLOTS(FAST_SLOTS), .FAST_DIV(FAST_DIV),
    .SLOW_DIV(SLOW_DIV)
  ) i_path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .slotIdx(slotCur), .devIdx(devCur),
    .txByte(txByte), .cfgWe(cfgWe), .cfgSlot(cfgSlot), .cfgDiv(cfgDiv),
    .misoI(misoI), .sclkO(sclkO), .mosiO(mosiO), .csN(csN),
    .selStrobeO(selStrobeO), .engDone(engDone), .rxByte(rxData)
  );

endmodule

// File: tb/test_bpSpiHost.sv
module test_bpSpiHost;

  localparam int NUM_SLOTS = 7;
  localparam int CHAIN_LEN = 2;
  localparam int LEN_W     = 4;
  localparam int DIV_W     = 8;
  localparam int SEL_W     = 8 * CHAIN_LEN;
  localparam int SLOT_W    = 3;
  localparam int DEV_W     = 5;

  typedef struct packed {
    logic [2:0] slot;
    logic [4:0] dev;
    logic [3:0] len;
    logic       setDiv;
    logic [7:0] div;
    logic [3:0] half;
  } vecT;

  localparam int NVEC = 6;
  localparam vecT VEC [NVEC] = '{
    '{3'd1, 5'd0,  4'd1,  1'b0, 8'd0, 4'd2},
    '{3'd3, 5'd5,  4'd3,  1'b0, 8'd0, 4'd6},
    '{3'd7, 5'd15, 4'd2,  1'b1, 8'd0, 4'd1},
    '{3'd2, 5'd8,  4'd4,  1'b0, 8'd0, 4'd2},
    '{3'd5, 5'd1,  4'd2,  1'b1, 8'd2, 4'd3},
    '{3'd4, 5'd7,  4'd15, 1'b1, 8'd0, 4'd1}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic                 reqValid = 1'b0;
  logic [SLOT_W-1:0]    reqSlot = '0;
  logic [DEV_W-1:0]     reqDev = '0;
  logic [LEN_W-1:0]     reqLen = '0;
  logic [7:0]           txByte;
  logic                 txTake, busy, done, err, rxValid;
  logic [7:0]           rxData;
  logic                 cfgWe = 1'b0;
  logic [SLOT_W-1:0]    cfgSlot = '0;
  logic [DIV_W-1:0]     cfgDiv = '0;
  logic [NUM_SLOTS-1:0] sclkO, mosiO, csN, selStrobeO;
  logic [NUM_SLOTS-1:0] misoI = '0;

  bpSpiHost #(.NUM_SLOTS(NUM_SLOTS), .CHAIN_LEN(CHAIN_LEN), .LEN_W(LEN_W),
              .DIV_W(DIV_W)) i_bpSpiHost (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSlot(reqSlot),
    .reqDev(reqDev), .reqLen(reqLen), .txByte(txByte), .txTake(txTake),
    .busy(busy), .done(done), .err(err), .rxData(rxData), .rxValid(rxValid),
    .cfgWe(cfgWe), .cfgSlot(cfgSlot), .cfgDiv(cfgDiv), .sclkO(sclkO),
    .mosiO(mosiO), .misoI(misoI), .csN(csN), .selStrobeO(selStrobeO)
  );

  int nChecks = 0;
  int nFails  = 0;

  task automatic check(input bit ok, input string tag, input longint act,
                       input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] respByte(int slot, int dev, int k);
    return 8'((slot * 37) ^ (dev * 11) ^ (k * 29) ^ 8'hC3);
  endfunction

  function automatic logic [7:0] txVal(int v, int k);
    return 8'(8'h3C ^ (v * 37) ^ (k * 81));
  endfunction

  // Transmit data source
  int curVec  = 0;
  int takeCnt = 0;
  assign txByte = txVal(curVec, takeCnt);
  always @(posedge clk) if (txTake) takeCnt <= takeCnt + 1;

  // Card model and pin monitor, sampled away from the active edge
  int              curSlot = 0;
  logic            prevSc, prevCs, prevSt, junk;
  logic [SEL_W-1:0] selSR, latched, csFallPat;
  logic [7:0]      inByte, txSh;
  int              bitIdx, kIdx, slvCnt;
  logic [7:0]      slvBytes [16];
  int              strobeRun, strobeLen, highRun;
  int              selHighMin, selHighMax, dataHighMin, dataHighMax;
  int              otherAct;
  bit              busySeen;

  task automatic resetModel();
    prevSc = 1'b0; prevCs = 1'b1; prevSt = 1'b0;
    selSR = '0; latched = '0; csFallPat = '0;
    inByte = '0; txSh = '0; bitIdx = 0; kIdx = 0; slvCnt = 0;
    strobeRun = 0; strobeLen = 0; highRun = 0;
    selHighMin = 999; selHighMax = 0; dataHighMin = 999; dataHighMax = 0;
    otherAct = 0; busySeen = 1'b0;
  endtask

  initial begin
    junk = 1'b0;
    resetModel();
  end

  always @(negedge clk) begin
    int s;
    logic sc, cs, st, mo;
    s = curSlot - 1;
    if (busy) busySeen = 1'b1;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (i != s && (sclkO[i] || mosiO[i] || !csN[i] || selStrobeO[i]))
        otherAct++;
    if (s >= 0) begin
      sc = sclkO[s]; cs = csN[s]; st = selStrobeO[s]; mo = mosiO[s];
      if (!cs && prevCs) begin
        csFallPat = latched;
        kIdx = 0; bitIdx = 0;
        txSh = respByte(curSlot, int'(reqDev), 0);
      end
      if (sc && !prevSc) begin
        if (cs) selSR = {selSR[SEL_W-2:0], mo};
        else begin
          inByte = {inByte[6:0], mo};
          bitIdx++;
          if (bitIdx == 8) begin
            if (slvCnt < 16) slvBytes[slvCnt] = inByte;
            slvCnt++;
          end
        end
      end
      if (!sc && prevSc && !cs) begin
        if (bitIdx == 8) begin
          kIdx++; bitIdx = 0;
          txSh = respByte(curSlot, int'(reqDev), kIdx);
        end else txSh = txSh << 1;
      end
      if (st && !prevSt) latched = selSR;
      if (st) strobeRun++;
      else if (prevSt) begin strobeLen = strobeRun; strobeRun = 0; end
      if (sc) highRun++;
      else if (prevSc) begin
        if (cs) begin
          if (highRun < selHighMin) selHighMin = highRun;
          if (highRun > selHighMax) selHighMax = highRun;
        end else begin
          if (highRun < dataHighMin) dataHighMin = highRun;
          if (highRun > dataHighMax) dataHighMax = highRun;
        end
        highRun = 0;
      end
      prevSc = sc; prevCs = cs; prevSt = st;
    end
    junk = ~junk;
    misoI = {NUM_SLOTS{junk}};
    if (s >= 0) misoI[s] = txSh[7];
  end

  task automatic cfgWrite(input int slot, input int div);
    @(negedge clk);
    cfgWe = 1'b1; cfgSlot = SLOT_W'(slot); cfgDiv = DIV_W'(div);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic runVec(input int v);
    vecT e;
    int rxCnt, guard;
    logic [SEL_W-1:0] expPat;
    e = VEC[v];
    if (e.setDiv) cfgWrite(int'(e.slot), int'(e.div));
    @(negedge clk);
    resetModel();
    curSlot = int'(e.slot); curVec = v; takeCnt = 0;
    reqValid = 1'b1; reqSlot = e.slot; reqDev = e.dev; reqLen = e.len;
    @(negedge clk);
    reqValid = 1'b0;
    rxCnt = 0; guard = 0;
    while (!done && guard < 20000) begin
      if (rxValid) begin
        check(rxData == respByte(int'(e.slot), int'(e.dev), rxCnt),
              $sformatf("R7 rx byte %0d vec %0d", rxCnt, v), rxData,
              respByte(int'(e.slot), int'(e.dev), rxCnt));
        rxCnt++;
      end
      @(negedge clk);
      guard++;
    end
    expPat = ~(SEL_W'(1) << (SEL_W - 1 - int'(e.dev)));
    check(done && !err, $sformatf("R8 done without err vec %0d", v), {done, err}, 2'b10);
    check(rxCnt == int'(e.len), $sformatf("R7 rx count vec %0d", v), rxCnt, e.len);
    check(takeCnt == int'(e.len), $sformatf("R5 txTake count vec %0d", v), takeCnt, e.len);
    check(slvCnt == int'(e.len), $sformatf("R5 card byte count vec %0d", v), slvCnt, e.len);
    for (int b = 0; b < int'(e.len) && b < slvCnt; b++)
      check(slvBytes[b] == txVal(v, b), $sformatf("R5 mosi byte %0d vec %0d", b, v),
            slvBytes[b], txVal(v, b));
    check(csFallPat == expPat, $sformatf("R2 R11 latched pattern at select vec %0d", v),
          csFallPat, expPat);
    check(selHighMin == 1 && selHighMax == 1, $sformatf("R3 select sclk high vec %0d", v),
          selHighMax, 1);
    check(dataHighMin == int'(e.half) && dataHighMax == int'(e.half),
          $sformatf("R6 data sclk high vec %0d", v), dataHighMax, e.half);
    check(strobeLen == 2, $sformatf("R4 strobe length vec %0d", v), strobeLen, 2);
    check(latched == '1, $sformatf("R8 idle pattern latched vec %0d", v), latched, '1);
    check(otherAct == 0, $sformatf("R9 other slots quiet vec %0d", v), otherAct, 0);
    @(negedge clk);
    check(!busy && csN == '1, $sformatf("R8 idle after done vec %0d", v), {busy, csN}, 8'h7F);
  endtask

  task automatic runReject(input int slot, input int dev, input int len, input string why);
    bit sawDone, sawErr, sawRx;
    @(negedge clk);
    resetModel();
    curSlot = 0;
    reqValid = 1'b1; reqSlot = SLOT_W'(slot); reqDev = DEV_W'(dev); reqLen = LEN_W'(len);
    @(negedge clk);
    reqValid = 1'b0;
    sawDone = done; sawErr = err; sawRx = 1'b0;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (rxValid) sawRx = 1'b1;
    end
    check(sawDone && sawErr, {"R1 reject flags ", why}, {sawDone, sawErr}, 2'b11);
    check(!busySeen && !sawRx, {"R1 reject stays idle ", why}, {busySeen, sawRx}, 0);
    check(otherAct == 0, {"R1 reject no pin activity ", why}, otherAct, 0);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog all requirements act=timeout exp=finish");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs during reset
    check(csN == '1 && sclkO == '0 && mosiO == '0 && selStrobeO == '0,
          "R10 pins in reset", {csN, sclkO, mosiO, selStrobeO}, 28'hFE00000);
    check(!busy && !done && !err && !rxValid, "R10 status in reset",
          {busy, done, err, rxValid}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(csN == '1 && sclkO == '0 && selStrobeO == '0 && !busy,
          "R10 pins after reset", {busy, csN}, 8'h7F);

    for (int v = 0; v < NVEC; v++) runVec(v);

    runReject(0, 0, 1, "slot 0");
    runReject(3, SEL_W, 1, "device out of range");
    runReject(6, 2, 0, "zero length");
    runVec(0);
    finishRun();
  end

endmodule